// File: doc/BRIEF.md
# Edge-Latched Interrupt Collector

This block gathers a small group of asynchronous interrupt sources into a sticky status register and drives one level-sensitive interrupt request line. Each source passes through a two-flop synchronizer. After that, a rising-edge detector compares the synchronized level with its value one cycle earlier. A rising edge sets the matching status bit, but only while that source's enable bit is 1. The default group has six sources, and status bit i always belongs to source i.

There is no clear register. Software clears a status bit by writing 0 to that source's enable bit. A status bit is held at 0 for as long as its enable bit stays 0. An edge that arrives while the source is disabled is dropped and is not stored. Writing the enable bit back to 1 arms the source for the next rising edge.

A two-state machine drives the request line. In state QUIET the line is low. The transition QUIET->RAISED happens when the status register changes from all-zero to non-zero. In state RAISED the line is high. RAISED stays in RAISED while any status bit is set. The transition RAISED->QUIET happens once every status bit has been cleared. QUIET stays in QUIET while the status is zero.

Top module: `edge_irq_collector`

## Requirements
- R1: After reset, the enable register and the status register are zero and `irq_out` is low.
- R2: Take a source that is enabled and whose synchronized level is low. When it goes high, its status bit reads 1 after the third rising clock edge following the change (two synchronizer stages plus the latch), and not earlier.
- R3: A rising edge on a disabled source is ignored. Enabling that source later, while the source is still high, leaves its status bit at 0.
- R4: If `en_wdata` bit i is 0 during a cycle with `en_we` high, status bit i reads 0 after that clock edge. It stays 0 for as long as the enable bit is 0.
- R5: If an enable write and a detected rising edge fall in the same cycle, the newly written enable bit decides whether the edge is latched.
- R6: `irq_out` goes high one clock edge after the status register changes from all-zero to non-zero (transition QUIET->RAISED).
- R7: `irq_out` stays high while any status bit is 1. It goes low one clock edge after the status register becomes all-zero (transition RAISED->QUIET).
- R8: `status_out` bit i always shows the latched state of source i. The read has no side effect.
- R9: Only a rising edge sets a status bit. A source held high, or a falling edge, does not set the bit again after it has been cleared and re-enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | 6 | Asynchronous interrupt source levels, bit i is source i |
| en_we | input | 1 | Write strobe for the enable register |
| en_wdata | input | 6 | New enable value, bit i enables source i |
| status_out | output | 6 | Latched status register, bit i belongs to source i |
| irq_out | output | 1 | Level interrupt request, high in state RAISED |

## Verification
Two events can land in the same cycle: a detected rising edge that is about to be latched, and an enable write that changes that source's enable bit. The bench produces this collision on purpose. It starts a source edge exactly two clock edges before the write, so that the detection and the write share one cycle. It does this once with the write turning the bit on and once with the write turning it off, and checks the status after the edge against the new enable value. In the random phase, writes and source toggles are drawn independently every cycle, so such collisions also happen by chance. A bench-side reference model, updated every edge, judges each of them.

// File: rtl/irqcol_pkg.sv
package irqcol_pkg;
    typedef enum logic {
        QUIET  = 1'b0,
        RAISED = 1'b1
    } irq_state_t;
endpackage

// File: rtl/irqcol_sync.sv
module irqcol_sync #(
    parameter int W      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] pipe [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[0] <= '0;
                else        pipe[0] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[g] <= '0;
                else        pipe[g] <= pipe[g-1];
            end
        end
    end

    assign dout = pipe[STAGES-1];
endmodule

// File: rtl/irqcol_edge.sv
module irqcol_edge #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level,
    output logic [W-1:0] rise
);
    logic [W-1:0] level_d;

    always_ff @(posedge clk) begin
        if (!rst_n) level_d <= '0;
        else        level_d <= level;
    end

    assign rise = level & ~level_d;

    // R9: a rising pulse lasts a single cycle for a steady high level
    p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((rise & $past(rise)) == '0));
endmodule

// File: rtl/irqcol_status.sv
module irqcol_status #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] rise,
    input  logic         en_we,
    input  logic [W-1:0] en_wdata,
    output logic [W-1:0] status_q
);
    logic [W-1:0] en_q;
    logic [W-1:0] en_next;

    assign en_next = en_we ? en_wdata : en_q;

    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_next;
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)            status_q[i] <= 1'b0;
            else if (!en_next[i])  status_q[i] <= 1'b0;
            else if (rise[i])      status_q[i] <= 1'b1;
        end
    end

    // R4: no status bit survives while its enable bit is zero
    p_clear_disabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & ~en_q) == '0));

    // R9: a bit can only become set after a detected edge
    p_set_needs_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & ~$past(status_q) & ~$past(rise)) == '0));

    // R8: set bits stay set while the enable holds and no write clears them
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_we) |=> ((($past(status_q) & $past(en_q)) & ~status_q) == '0));
endmodule

// File: rtl/irqcol_fsm.sv
module irqcol_fsm
    import irqcol_pkg::*;
#(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] status,
    output logic         irq
);
    irq_state_t state_q;
    irq_state_t state_d;
    logic       any_set;

    assign any_set = |status;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            QUIET:   if (any_set)  state_d = RAISED;
            RAISED:  if (!any_set) state_d = QUIET;
            default: state_d = QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        irq = (state_q == RAISED);
    end

    // R6: a non-zero status while quiet raises the line next cycle
    p_raise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (any_set && !irq) |=> irq);

    // R7: line holds while status is non-zero
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && any_set) |=> irq);

    // R7: zero status drops the line next cycle
    p_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_set) |=> !irq);
endmodule

// File: rtl/edge_irq_collector.sv
module edge_irq_collector #(
    parameter int N_SRC       = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_in,
    input  logic             en_we,
    input  logic [N_SRC-1:0] en_wdata,
    output logic [N_SRC-1:0] status_out,
    output logic             irq_out
);
    logic [N_SRC-1:0] src_sync;
    logic [N_SRC-1:0] src_rise;

    irqcol_sync #(.W(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (src_in),
        .dout  (src_sync)
    );

    irqcol_edge #(.W(N_SRC)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (src_sync),
        .rise  (src_rise)
    );

    irqcol_status #(.W(N_SRC)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise     (src_rise),
        .en_we    (en_we),
        .en_wdata (en_wdata),
        .status_q (status_out)
    );

    irqcol_fsm #(.W(N_SRC)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .status (status_out),
        .irq    (irq_out)
    );

    // R1: outputs are clear in the cycle after reset
    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (status_out == '0 && !irq_out));
endmodule

// File: tb/sim_edge_irq_collector.sv
module sim_edge_irq_collector;
    localparam int N = 6;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] src_in = '0;
    logic         en_we = 1'b0;
    logic [N-1:0] en_wdata = '0;
    logic [N-1:0] status_out;
    logic         irq_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit model_on = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    edge_irq_collector u0 (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .en_we(en_we),
        .en_wdata(en_wdata), .status_out(status_out), .irq_out(irq_out)
    );

    // reference model built from the requirement timing
    logic [N-1:0] m_s1, m_s2, m_s3, m_en, m_st;
    logic         m_irq;

    function automatic logic [N-1:0] next_status(input logic [N-1:0] st,
        input logic [N-1:0] s2, input logic [N-1:0] s3,
        input logic [N-1:0] en_new);
        return (st | (s2 & ~s3 & en_new)) & en_new;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 <= '0; m_s2 <= '0; m_s3 <= '0;
            m_en <= '0; m_st <= '0; m_irq <= 1'b0;
        end else begin
            m_s1 <= src_in;
            m_s2 <= m_s1;
            m_s3 <= m_s2;
            m_en <= en_we ? en_wdata : m_en;
            m_st <= next_status(m_st, m_s2, m_s3, en_we ? en_wdata : m_en);
            m_irq <= (m_st != '0);
        end
    end

    always @(negedge clk) begin
        if (model_on && !done) begin
            n_cmp++;
            if (status_out !== m_st) begin
                n_bad++;
                $display("FAIL R5/R8 model status: actual %h expected %h", status_out, m_st);
            end
            n_cmp++;
            if (irq_out !== m_irq) begin
                n_bad++;
                $display("FAIL R6/R7 model irq: actual %b expected %b", irq_out, m_irq);
            end
        end
    end

    task automatic check(input string tag, input logic [N:0] act, input logic [N:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic wr_en(input logic [N-1:0] v);
        en_we = 1'b1; en_wdata = v;
        step(1);
        en_we = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        step(3);
        rst_n = 1'b1;
        step(1);
        check("R1 status", {1'b0, status_out}, '0);
        check("R1 irq", {{N{1'b0}}, irq_out}, '0);
        model_on = 1'b1;

        wr_en(6'h3F);
        src_in = 6'h01;
        step(2);
        check("R2 early", {1'b0, status_out}, '0);
        step(1);
        check("R2 R8 set", {1'b0, status_out}, 7'h01);
        check("R6 not yet", {{N{1'b0}}, irq_out}, '0);
        step(1);
        check("R6 raised", {{N{1'b0}}, irq_out}, 7'h01);

        wr_en(6'h3E);
        check("R4 cleared", {1'b0, status_out}, '0);
        check("R7 lag", {{N{1'b0}}, irq_out}, 7'h01);
        step(1);
        check("R7 dropped", {{N{1'b0}}, irq_out}, '0);

        wr_en(6'h3F);
        step(4);
        check("R9 held level", {1'b0, status_out}, '0);
        src_in = 6'h00;
        step(4);
        check("R9 falling", {1'b0, status_out}, '0);

        wr_en(6'h3D);
        src_in = 6'h02;
        step(4);
        check("R3 disabled edge", {1'b0, status_out}, '0);
        wr_en(6'h3F);
        step(3);
        check("R3 not remembered", {1'b0, status_out}, '0);

        src_in = 6'h0E;
        step(3);
        check("R8 two bits", {1'b0, status_out}, 7'h0C);
        wr_en(6'h3B);
        check("R4 partial", {1'b0, status_out}, 7'h08);
        check("R7 hold", {{N{1'b0}}, irq_out}, 7'h01);
        wr_en(6'h33);
        check("R4 all clear", {1'b0, status_out}, '0);
        step(1);
        check("R7 low", {{N{1'b0}}, irq_out}, '0);

        // R5: enable written in the same cycle the edge is detected
        wr_en(6'h2F);
        src_in = 6'h1E;
        step(2);
        wr_en(6'h3F);
        check("R5 enable wins", {1'b0, status_out}, 7'h10);
        src_in = 6'h3E;
        step(2);
        wr_en(6'h1F);
        check("R5 disable wins", {1'b0, status_out}, 7'h10);
        wr_en(6'h00);
        src_in = 6'h00;
        step(4);

        for (int c = 0; c < 4000; c++) begin
            src_in = src_in ^ 6'($urandom & $urandom);
            if (($urandom % 8) == 0) begin
                en_we = 1'b1;
                en_wdata = 6'($urandom | $urandom);
            end else begin
                en_we = 1'b0;
            end
            step(1);
        end
        en_we = 1'b0;
        step(2);
        finish_run();
    end
endmodule